// File: doc/BRIEF.md
# Dual-Issue Pair Hazard Checker

This block sits in the decode stage of a two-wide in-order core. Each cycle it looks at the instruction pair offered by the fetch buffer. The even slot holds the older instruction and the odd slot the younger one. The block decides whether both may issue together, only the even one, or neither. It classifies each opcode into one of four execution classes. It checks the class pair against an order-sensitive conflict table, looks for equal destinations (write-after-write) and for the odd instruction reading the even one's result (read-after-write inside the pair). It also returns a forwarding select for every source operand of both slots.

The pair interface follows valid/ready rules. `ev_issue` and `od_issue` act as per-slot ready signals, and a slot is consumed in a cycle where it is valid and its issue output is high. When only the even slot is consumed, the fetch buffer moves the odd instruction into the even slot for the next cycle, where it pairs with the next fetched instruction. `hold` is back-pressure from later stages and stops all issue in that cycle. The block keeps a small record of the destinations issued in the two previous cycles, which stand for the EX and WB stages. It uses that record to choose forwarding sources.

Top module: `dual_issue_hazard_unit`

## Requirements
- R1: The class output is ALU (0) for opcode[5]=0, MUL (1) for opcode[5:3]=100, BR (2) for opcode[5:3]=101 and LS (3) for opcode[5:4]=11.
- R2: ALU, MUL and loads (LS with opcode[3]=0) write their destination. Branches and stores (LS with opcode[3]=1) have no destination.
- R3: `ev_issue` is high exactly when `ev_valid` is high and `hold` is low. `od_issue` is never high unless `ev_issue` is high and `od_valid` is high.
- R4: The odd slot does not issue for the (even, odd) class pairs MUL/MUL, MUL/BR, BR/MUL, BR/BR, BR/LS and LS/LS. Every other pairing may dual-issue, including LS/BR.
- R5: If both slots write the same nonzero destination, the odd slot does not issue.
- R6: If the even slot writes a nonzero destination that either odd source names, the odd slot does not issue.
- R7: While `hold` is high neither slot issues, and the held instructions never appear as forwarding producers.
- R8: `split` is high exactly when the even slot issues, the odd slot is valid, and R4, R5 or R6 blocks the odd slot.
- R9: Each forwarding select takes the first matching producer in this order: EX odd (2), EX even (1), WB odd (4), WB even (3). With no match it selects the register file (0).
- R10: Register 0 and instructions with no destination never cause a WAW or RAW block and are never forwarding producers. A source naming register 0 always selects the register file.
- R11: An instruction issued with a written destination in cycle t is an EX producer in cycle t+1, a WB producer in cycle t+2, and no longer a producer afterwards. Reset clears all producers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Back-pressure from later stages; blocks all issue |
| ev_valid | input | 1 | Even (older) slot holds an instruction |
| ev_opcode | input | 6 | Even slot opcode |
| ev_rd | input | REG_W | Even slot destination register |
| ev_rs1 | input | REG_W | Even slot first source |
| ev_rs2 | input | REG_W | Even slot second source |
| od_valid | input | 1 | Odd (younger) slot holds an instruction |
| od_opcode | input | 6 | Odd slot opcode |
| od_rd | input | REG_W | Odd slot destination register |
| od_rs1 | input | REG_W | Odd slot first source |
| od_rs2 | input | REG_W | Odd slot second source |
| ev_issue | output | 1 | Even slot issues (consumed) this cycle |
| od_issue | output | 1 | Odd slot issues (consumed) this cycle |
| split | output | 1 | Pair split: only the even slot issues because of a conflict |
| ev_class | output | 2 | Execution class of the even opcode |
| od_class | output | 2 | Execution class of the odd opcode |
| ev_fwd1 | output | 3 | Forwarding select for even first source |
| ev_fwd2 | output | 3 | Forwarding select for even second source |
| od_fwd1 | output | 3 | Forwarding select for odd first source |
| od_fwd2 | output | 3 | Forwarding select for odd second source |

## Verification
The hardest case to reach is the forwarding priority in which one register has a live producer in the EX odd lane and an older live producer in the WB even lane at the same time. It needs two back-to-back dual-issued pairs that write the register from opposite lanes, with no conflict inside either pair. The stimulus builds exactly that sequence and then follows the register for two more cycles as it drops to the WB odd lane and then to the register file. The scoreboard keeps its own EX/WB producer model, updated from the expected issue decisions, so stale producers after a hold or a split are also caught.

// File: rtl/dih_pkg.sv
package dih_pkg;
  localparam int OPC_W = 6;
  localparam int LANES = 2;

  typedef enum logic [1:0] {
    CL_ALU = 2'd0,
    CL_MUL = 2'd1,
    CL_BR  = 2'd2,
    CL_LS  = 2'd3
  } exec_class_e;

  typedef enum logic [2:0] {
    FW_RF    = 3'd0,
    FW_EX_EV = 3'd1,
    FW_EX_OD = 3'd2,
    FW_WB_EV = 3'd3,
    FW_WB_OD = 3'd4
  } fwd_sel_e;

  function automatic exec_class_e op_class(input logic [OPC_W-1:0] op);
    if (!op[5])                 return CL_ALU;
    else if (op[4])             return CL_LS;
    else if (op[3])             return CL_BR;
    else                        return CL_MUL;
  endfunction

  function automatic logic op_writes(input logic [OPC_W-1:0] op);
    exec_class_e c;
    c = op_class(op);
    return (c == CL_ALU) || (c == CL_MUL) || ((c == CL_LS) && !op[3]);
  endfunction
endpackage

// File: rtl/dih_slot_decode.sv
module dih_slot_decode
  import dih_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [REG_W-1:0] rd,
  output exec_class_e      cls,
  output logic             wr
);
  always_comb begin
    cls = op_class(opcode);
    wr  = op_writes(opcode) && (rd != '0);
  end
endmodule

// File: rtl/dih_pair_check.sv
module dih_pair_check
  import dih_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  exec_class_e      cls_ev,
  input  exec_class_e      cls_od,
  input  logic             wr_ev,
  input  logic             wr_od,
  input  logic [REG_W-1:0] rd_ev,
  input  logic [REG_W-1:0] rd_od,
  input  logic [REG_W-1:0] rs1_od,
  input  logic [REG_W-1:0] rs2_od,
  output logic             struct_c,
  output logic             waw_c,
  output logic             raw_c
);
  always_comb begin
    unique case (cls_ev)
      CL_MUL:  struct_c = (cls_od == CL_MUL) || (cls_od == CL_BR);
      CL_BR:   struct_c = (cls_od != CL_ALU);
      CL_LS:   struct_c = (cls_od == CL_LS);
      default: struct_c = 1'b0;
    endcase
    waw_c = wr_ev && wr_od && (rd_ev == rd_od);
    raw_c = wr_ev && ((rs1_od == rd_ev) || (rs2_od == rd_ev));
  end
endmodule

// File: rtl/dih_inflight.sv
module dih_inflight
  import dih_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES-1:0]            iss_wr,
  input  logic [LANES-1:0][REG_W-1:0] iss_rd,
  output logic [LANES-1:0]            ex_vld,
  output logic [LANES-1:0][REG_W-1:0] ex_rd,
  output logic [LANES-1:0]            wb_vld,
  output logic [LANES-1:0][REG_W-1:0] wb_rd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_vld <= '0;
      ex_rd  <= '0;
      wb_vld <= '0;
      wb_rd  <= '0;
    end else begin
      wb_vld <= ex_vld;
      wb_rd  <= ex_rd;
      ex_vld <= iss_wr;
      ex_rd  <= iss_rd;
    end
  end
endmodule

// File: rtl/dih_fwd_pick.sv
module dih_fwd_pick
  import dih_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0]            src,
  input  logic [LANES-1:0]            ex_vld,
  input  logic [LANES-1:0][REG_W-1:0] ex_rd,
  input  logic [LANES-1:0]            wb_vld,
  input  logic [LANES-1:0][REG_W-1:0] wb_rd,
  output fwd_sel_e                    sel
);
  always_comb begin
    sel = FW_RF;
    if (src != '0) begin
      if (ex_vld[1] && ex_rd[1] == src)      sel = FW_EX_OD;
      else if (ex_vld[0] && ex_rd[0] == src) sel = FW_EX_EV;
      else if (wb_vld[1] && wb_rd[1] == src) sel = FW_WB_OD;
      else if (wb_vld[0] && wb_rd[0] == src) sel = FW_WB_EV;
    end
  end
endmodule

// File: rtl/dual_issue_hazard_unit.sv
module dual_issue_hazard_unit
  import dih_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             ev_valid,
  input  logic [5:0]       ev_opcode,
  input  logic [REG_W-1:0] ev_rd,
  input  logic [REG_W-1:0] ev_rs1,
  input  logic [REG_W-1:0] ev_rs2,
  input  logic             od_valid,
  input  logic [5:0]       od_opcode,
  input  logic [REG_W-1:0] od_rd,
  input  logic [REG_W-1:0] od_rs1,
  input  logic [REG_W-1:0] od_rs2,
  output logic             ev_issue,
  output logic             od_issue,
  output logic             split,
  output logic [1:0]       ev_class,
  output logic [1:0]       od_class,
  output logic [2:0]       ev_fwd1,
  output logic [2:0]       ev_fwd2,
  output logic [2:0]       od_fwd1,
  output logic [2:0]       od_fwd2
);
  localparam int NSRC = 2 * LANES;

  logic [LANES-1:0][OPC_W-1:0] opc;
  logic [LANES-1:0][REG_W-1:0] rd;
  exec_class_e                 cls [LANES];
  logic [LANES-1:0]            wr;

  assign opc[0] = ev_opcode;
  assign opc[1] = od_opcode;
  assign rd[0]  = ev_rd;
  assign rd[1]  = od_rd;

  for (genvar l = 0; l < LANES; l++) begin : g_dec
    dih_slot_decode #(.REG_W(REG_W)) u_dec (
      .opcode(opc[l]),
      .rd    (rd[l]),
      .cls   (cls[l]),
      .wr    (wr[l])
    );
  end

  logic struct_c, waw_c, raw_c, blocked;

  dih_pair_check #(.REG_W(REG_W)) u_pair (
    .cls_ev  (cls[0]),
    .cls_od  (cls[1]),
    .wr_ev   (wr[0]),
    .wr_od   (wr[1]),
    .rd_ev   (ev_rd),
    .rd_od   (od_rd),
    .rs1_od  (od_rs1),
    .rs2_od  (od_rs2),
    .struct_c(struct_c),
    .waw_c   (waw_c),
    .raw_c   (raw_c)
  );

  assign blocked  = struct_c || waw_c || raw_c;
  assign ev_issue = ev_valid && !hold;
  assign od_issue = ev_issue && od_valid && !blocked;
  assign split    = ev_issue && od_valid && blocked;
  assign ev_class = cls[0];
  assign od_class = cls[1];

  logic [LANES-1:0]            iss_wr;
  logic [LANES-1:0]            ex_vld, wb_vld;
  logic [LANES-1:0][REG_W-1:0] ex_rd, wb_rd;

  assign iss_wr[0] = ev_issue && wr[0];
  assign iss_wr[1] = od_issue && wr[1];

  dih_inflight #(.REG_W(REG_W)) u_track (
    .clk   (clk),
    .rst_n (rst_n),
    .iss_wr(iss_wr),
    .iss_rd(rd),
    .ex_vld(ex_vld),
    .ex_rd (ex_rd),
    .wb_vld(wb_vld),
    .wb_rd (wb_rd)
  );

  logic [NSRC-1:0][REG_W-1:0] srcs;
  fwd_sel_e                   sel [NSRC];

  assign srcs[0] = ev_rs1;
  assign srcs[1] = ev_rs2;
  assign srcs[2] = od_rs1;
  assign srcs[3] = od_rs2;

  for (genvar s = 0; s < NSRC; s++) begin : g_fwd
    dih_fwd_pick #(.REG_W(REG_W)) u_pick (
      .src   (srcs[s]),
      .ex_vld(ex_vld),
      .ex_rd (ex_rd),
      .wb_vld(wb_vld),
      .wb_rd (wb_rd),
      .sel   (sel[s])
    );
  end

  assign ev_fwd1 = sel[0];
  assign ev_fwd2 = sel[1];
  assign od_fwd1 = sel[2];
  assign od_fwd2 = sel[3];
endmodule

// File: rtl/dih_checker.sv
module dih_checker
  import dih_pkg::*;
#(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold,
  input logic [5:0]       ev_opcode,
  input logic [REG_W-1:0] ev_rd,
  input logic [REG_W-1:0] ev_rs1,
  input logic [5:0]       od_opcode,
  input logic [REG_W-1:0] od_rd,
  input logic [REG_W-1:0] od_rs1,
  input logic [REG_W-1:0] od_rs2,
  input logic             ev_issue,
  input logic             od_issue,
  input logic [1:0]       ev_class,
  input logic [1:0]       od_class,
  input logic [2:0]       ev_fwd1
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_odd_after_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    od_issue |-> ev_issue);

  p_struct_table_r4: assert property (@(posedge clk) disable iff (!rst_n)
    od_issue |-> !((ev_class == 2'd1 && (od_class == 2'd1 || od_class == 2'd2)) ||
                   (ev_class == 2'd2 && od_class != 2'd0) ||
                   (ev_class == 2'd3 && od_class == 2'd3)));

  p_no_waw_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (od_issue && ev_rd == od_rd && ev_rd != '0) |->
      !(op_writes(ev_opcode) && op_writes(od_opcode)));

  p_no_raw_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (od_issue && ev_rd != '0 && op_writes(ev_opcode)) |->
      (od_rs1 != ev_rd && od_rs2 != ev_rd));

  p_hold_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (!ev_issue && !od_issue));

  p_ex_forward_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(ev_issue && op_writes(ev_opcode) && ev_rd != '0) &&
     ev_rs1 == $past(ev_rd)) |-> ev_fwd1 == 3'd1);

  p_zero_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rs1 == '0) |-> ev_fwd1 == 3'd0);
endmodule

bind dual_issue_hazard_unit dih_checker #(.REG_W(REG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hold     (hold),
  .ev_opcode(ev_opcode),
  .ev_rd    (ev_rd),
  .ev_rs1   (ev_rs1),
  .od_opcode(od_opcode),
  .od_rd    (od_rd),
  .od_rs1   (od_rs1),
  .od_rs2   (od_rs2),
  .ev_issue (ev_issue),
  .od_issue (od_issue),
  .ev_class (ev_class),
  .od_class (od_class),
  .ev_fwd1  (ev_fwd1)
);

// File: tb/sim_dual_issue_hazard_unit.sv
module sim_dual_issue_hazard_unit;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;
  localparam logic [5:0] OP_ALU = 6'h01, OP_MUL = 6'h20, OP_BR = 6'h28,
                         OP_LD = 6'h30, OP_ST = 6'h38;

  logic clk = 0, rst_n = 0, hold = 0;
  logic ev_valid = 0, od_valid = 0;
  logic [5:0] ev_opcode = 0, od_opcode = 0;
  logic [RW-1:0] ev_rd = 0, ev_rs1 = 0, ev_rs2 = 0, od_rd = 0, od_rs1 = 0, od_rs2 = 0;
  logic ev_issue, od_issue, split;
  logic [1:0] ev_class, od_class;
  logic [2:0] ev_fwd1, ev_fwd2, od_fwd1, od_fwd2;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_issue_hazard_unit #(.REG_W(RW)) u0 (.*);

  typedef struct {
    logic ei, oi, sp;
    logic [1:0] ce, co;
    logic [2:0] f [4];
    string tag;
  } exp_t;

  exp_t q [$];
  int checks = 0, failures = 0;
  bit done = 0;

  // bench-side producer model
  logic m_exv [2], m_wbv [2];
  logic [RW-1:0] m_exr [2], m_wbr [2];
  logic l_wv [2];
  logic [RW-1:0] l_rd [2];

  function automatic logic [1:0] b_cls(input logic [5:0] op);
    if (op[5] == 1'b0) return 2'd0;
    if (op[5:4] == 2'b11) return 2'd3;
    return op[3] ? 2'd2 : 2'd1;
  endfunction

  function automatic logic b_wr(input logic [5:0] op, input logic [RW-1:0] r);
    logic [1:0] c;
    c = b_cls(op);
    return (r != 0) && (c == 2'd0 || c == 2'd1 || (c == 2'd3 && !op[3]));
  endfunction

  function automatic logic [2:0] b_fwd(input logic [RW-1:0] s);
    if (s == 0) return 3'd0;
    if (m_exv[1] && m_exr[1] == s) return 3'd2;
    if (m_exv[0] && m_exr[0] == s) return 3'd1;
    if (m_wbv[1] && m_wbr[1] == s) return 3'd4;
    if (m_wbv[0] && m_wbr[0] == s) return 3'd3;
    return 3'd0;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic pair(input logic h,
                      input logic ev, input logic [5:0] eo, input int er, input int e1, input int e2,
                      input logic ov, input logic [5:0] oo, input int orr, input int o1, input int o2,
                      input string tag);
    exp_t x;
    logic we, wo, st, blk;
    logic [1:0] ce, co;
    @(posedge clk);
    m_wbv = m_exv; m_wbr = m_exr;
    m_exv = l_wv;  m_exr = l_rd;
    #1;
    hold = h; ev_valid = ev; ev_opcode = eo; ev_rd = er[RW-1:0];
    ev_rs1 = e1[RW-1:0]; ev_rs2 = e2[RW-1:0];
    od_valid = ov; od_opcode = oo; od_rd = orr[RW-1:0];
    od_rs1 = o1[RW-1:0]; od_rs2 = o2[RW-1:0];
    ce = b_cls(eo); co = b_cls(oo);
    we = b_wr(eo, ev_rd); wo = b_wr(oo, od_rd);
    st = (ce == 1 && (co == 1 || co == 2)) || (ce == 2 && co != 0) || (ce == 3 && co == 3);
    blk = st || (we && wo && ev_rd == od_rd) || (we && (od_rs1 == ev_rd || od_rs2 == ev_rd));
    x.tag = tag; x.ce = ce; x.co = co;
    x.ei = ev && !h;
    x.oi = x.ei && ov && !blk;
    x.sp = x.ei && ov && blk;
    x.f[0] = b_fwd(ev_rs1); x.f[1] = b_fwd(ev_rs2);
    x.f[2] = b_fwd(od_rs1); x.f[3] = b_fwd(od_rs2);
    l_wv[0] = x.ei && we; l_rd[0] = ev_rd;
    l_wv[1] = x.oi && wo; l_rd[1] = od_rd;
    q.push_back(x);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      check(x.tag, "ev_issue", ev_issue, x.ei);
      check(x.tag, "od_issue", od_issue, x.oi);
      check(x.tag, "split", split, x.sp);
      check("R1", "ev_class", ev_class, x.ce);
      check("R1", "od_class", od_class, x.co);
      check(x.tag, "ev_fwd1", ev_fwd1, x.f[0]);
      check(x.tag, "ev_fwd2", ev_fwd2, x.f[1]);
      check(x.tag, "od_fwd1", od_fwd1, x.f[2]);
      check(x.tag, "od_fwd2", od_fwd2, x.f[3]);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_exv[i] = 0; m_wbv[i] = 0; l_wv[i] = 0;
      m_exr[i] = 0; m_wbr[i] = 0; l_rd[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R11 reset: no producers; R3 plain dual issue
    pair(0, 1, OP_ALU, 1, 2, 3,  1, OP_ALU, 4, 5, 6, "R11");
    // R4 MUL/MUL split, R9 EX even / EX odd forwarding
    pair(0, 1, OP_MUL, 7, 1, 4,  1, OP_MUL, 8, 1, 4, "R4");
    // R9 WB and EX, R4 MUL/BR
    pair(0, 1, OP_MUL, 8, 1, 7,  1, OP_BR, 0, 4, 0, "R9");
    pair(0, 1, OP_BR, 0, 0, 0,   1, OP_MUL, 3, 0, 0, "R4");
    pair(0, 1, OP_BR, 0, 0, 0,   1, OP_LD, 3, 0, 0, "R4");
    pair(0, 1, OP_BR, 0, 0, 0,   1, OP_BR, 0, 0, 0, "R4");
    pair(0, 1, OP_LD, 2, 0, 0,   1, OP_ST, 0, 0, 0, "R4");
    pair(0, 1, OP_ST, 0, 0, 0,   1, OP_BR, 0, 0, 0, "R4");
    pair(0, 1, OP_MUL, 3, 0, 0,  1, OP_LD, 5, 0, 0, "R8");
    pair(0, 1, OP_LD, 6, 0, 0,   1, OP_MUL, 9, 0, 0, "R8");
    pair(0, 1, OP_ALU, 11, 0, 0, 1, OP_BR, 0, 0, 0, "R8");
    pair(0, 1, OP_MUL, 11, 0, 0, 1, OP_ALU, 12, 0, 0, "R8");
    // R5 WAW
    pair(0, 1, OP_ALU, 9, 0, 0,  1, OP_ALU, 9, 0, 0, "R5");
    pair(0, 1, OP_LD, 9, 0, 0,   1, OP_MUL, 9, 0, 0, "R5");
    // R2 store and branch have no destination
    pair(0, 1, OP_ST, 9, 0, 0,   1, OP_ALU, 9, 0, 0, "R2");
    pair(0, 1, OP_ALU, 9, 0, 0,  1, OP_ST, 9, 0, 0, "R2");
    // R10 register 0
    pair(0, 1, OP_ALU, 0, 0, 0,  1, OP_ALU, 0, 0, 0, "R10");
    // R6 RAW inside pair
    pair(0, 1, OP_ALU, 10, 0, 0, 1, OP_ALU, 14, 10, 0, "R6");
    pair(0, 1, OP_ALU, 10, 0, 0, 1, OP_ALU, 14, 0, 10, "R6");
    pair(0, 1, OP_ST, 10, 0, 0,  1, OP_ALU, 14, 10, 0, "R2");
    pair(0, 1, OP_BR, 10, 0, 0,  1, OP_ALU, 15, 10, 0, "R10");
    // R9 priority: reg 12 in WB even and EX odd together
    pair(0, 1, OP_ALU, 12, 0, 0, 1, OP_ALU, 13, 0, 0, "R9");
    pair(0, 1, OP_ALU, 14, 0, 0, 1, OP_ALU, 12, 0, 0, "R9");
    pair(0, 1, OP_ALU, 1, 12, 13, 1, OP_ALU, 2, 12, 14, "R9");
    pair(0, 1, OP_ALU, 0, 12, 14, 1, OP_ALU, 0, 1, 2, "R11");
    pair(0, 1, OP_ALU, 0, 12, 1, 1, OP_ALU, 0, 2, 13, "R11");
    // R7 hold: nothing issues and no producer appears
    pair(1, 1, OP_ALU, 15, 0, 0, 1, OP_ALU, 16, 0, 0, "R7");
    pair(0, 1, OP_ALU, 0, 15, 16, 1, OP_ALU, 0, 15, 16, "R7");
    // R3 odd alone never issues
    pair(0, 0, OP_ALU, 17, 0, 0, 1, OP_ALU, 18, 0, 0, "R3");
    pair(0, 1, OP_ALU, 0, 17, 18, 0, OP_ALU, 0, 0, 0, "R3");
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule